// File: doc/BRIEF.md
# Serial CRC-32 Frame Check Generator

This block produces the 32-bit frame check sequence for a token-ring or Ethernet-style frame on the transmit side, one bit per clock. The MAC pulses a start-of-frame strobe and then presents the covered frame bits on a serial input with a valid strobe. The covered bits are the frame control byte, the destination and source addresses, the optional routing field and the information field. The block divides this bit stream by the standard 32-bit generator polynomial. The remainder register is preset to all ones at the start of each frame.

When the MAC signals the end of the covered data, the remainder is already complete. The block then sends its complement as 32 serial bits, most significant first, with an output valid strobe. It follows them with a one-cycle done pulse. The MAC places these bits directly after the information field. While the check word is being sent, incoming bits and start strobes are ignored. A new frame can begin in the cycle after done.

Top module: `fcs32_serial_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it is released until a frame ends, `fcs_vld_o` and `done_o` stay low.
- R2: The emitted word is the one's complement of the remainder. The remainder is computed with the polynomial 0x04C11DB7 (x^32 term implied), register preset to 0xFFFFFFFF, and each byte's bits presented most significant first. The ASCII bytes "123456789" give 0xFC891918.
- R3: In the cycle after `eod_i` is sampled high, `fcs_vld_o` goes high. It stays high for exactly 32 consecutive cycles, carrying bit 31 of the check word first and bit 0 last on `fcs_bit_o`.
- R4: `done_o` is high for exactly one cycle, in the cycle right after the 32nd check bit, and never together with `fcs_vld_o`.
- R5: Bits presented with `bit_vld_i` high while the check word or done is being output have no effect on the output.
- R6: `sof_i` is accepted only when no frame is in progress. A strobe during data, during the check-word output or in the done cycle neither restarts the division nor opens a new frame.
- R7: A frame with no covered bits (`eod_i` as the first event after `sof_i`) yields the check word 0x00000000.
- R8: A frame whose covered bits are a message followed by that message's own check word yields the constant check word 0x38FB2284.
- R9: Cycles with `bit_vld_i` low inside a frame leave the remainder unchanged, whatever `bit_i` carries.
- R10: A bit presented in the same cycle as `eod_i` is the last covered bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_i | input | 1 | Start-of-frame strobe; presets the remainder |
| bit_vld_i | input | 1 | `bit_i` carries a covered frame bit this cycle |
| bit_i | input | 1 | Serial covered frame bit |
| eod_i | input | 1 | End of covered data; the check word follows |
| fcs_bit_o | output | 1 | Serial check word bit, most significant first |
| fcs_vld_o | output | 1 | `fcs_bit_o` is valid |
| done_o | output | 1 | One-cycle pulse after the last check bit |

## Verification
A divider that is wrong by a single feedback tap, a missed preset or a bit absorbed at the wrong time is invisible until the end of the data. It then shows up as at least one mismatching bit among the 32 emitted in the following cycles. A known-answer frame and the self-residue frame pin the polynomial, the preset and the complement independently of the bench model. A sequencer fault appears within one cycle of the event: a missing or late first valid bit after `eod_i`, a gap in the valid run, a run that is not 32 long, or done arriving early, late or twice. A start strobe accepted at the wrong time shows up as a wrong check word on the next frame.

// File: rtl/fcs32_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the serial frame check generator.
// Assumes the check width is 32 and the polynomial is written without its top term.
package fcs32_pkg;

    localparam int unsigned CHK_W = 32;
    localparam logic [CHK_W-1:0] CHK_POLY   = 32'h04C1_1DB7;
    localparam logic [CHK_W-1:0] CHK_PRESET = '1;

    // Frame sequencing phases.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_EMIT = 2'd2,
        PH_DONE = 2'd3
    } fcs_phase_e;

endpackage

// File: rtl/fcs32_divider.sv
`timescale 1ns/1ps
// Module: fcs32_divider
// Galois-form serial polynomial divider. It holds the running remainder, absorbs
// one data bit per absorb strobe, and shifts the remainder toward its MSB when
// emitting. Assumes absorb and shift are never requested in the same cycle;
// preset has priority over both.
module fcs32_divider #(
    parameter int unsigned        W      = 32,
    parameter logic [W-1:0]       POLY   = 32'h04C1_1DB7,
    parameter logic [W-1:0]       PRESET = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_i,
    input  logic         absorb_i,
    input  logic         data_i,
    input  logic         shift_i,
    output logic         msb_o
);

    logic [W-1:0] rem_q;
    logic [W-1:0] step_val;
    logic         fb;

    // Feedback term: incoming bit folded with the current top remainder bit.
    assign fb = data_i ^ rem_q[W-1];

    // One division step, built bit by bit from the polynomial taps.
    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_low
            assign step_val[i] = POLY[i] & fb;
        end else begin : g_mid
            assign step_val[i] = rem_q[i-1] ^ (POLY[i] & fb);
        end
    end

    // Remainder register: preset, absorb a bit, or shift out toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= PRESET;
        end else if (preset_i) begin
            rem_q <= PRESET;
        end else if (absorb_i) begin
            rem_q <= step_val;
        end else if (shift_i) begin
            rem_q <= {rem_q[W-2:0], 1'b0};
        end
    end

    assign msb_o = rem_q[W-1];

    // R2: a preset request leaves the register at the preset value.
    a_r2_preset_loads: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (rem_q == PRESET));

    // R5: the sequencer never asks for absorb and shift together.
    a_r5_absorb_shift_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(absorb_i && shift_i));

endmodule

// File: rtl/fcs32_sequencer.sv
`timescale 1ns/1ps
// Module: fcs32_sequencer
// Frame phase controller. It accepts a start strobe only when idle, gates data
// bits into the divider during the data phase, and counts the W emitted check
// bits. It then raises done for one cycle. Assumes the input strobes are synchronous.
module fcs32_sequencer
    import fcs32_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic vld_i,
    input  logic eod_i,
    output logic preset_o,
    output logic absorb_o,
    output logic shift_o,
    output logic emit_o,
    output logic done_o
);

    localparam int unsigned CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    fcs_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q;

    // Next phase from the current phase and the frame strobes.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (sof_i) phase_d = PH_DATA;
            PH_DATA: if (eod_i) phase_d = PH_EMIT;
            PH_EMIT: if (cnt_q == CNT_LAST) phase_d = PH_DONE;
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Strobes to the divider and the port-level flags.
    always_comb begin
        preset_o = (phase_q == PH_IDLE) && sof_i;
        absorb_o = (phase_q == PH_DATA) && vld_i;
        emit_o   = (phase_q == PH_EMIT);
        shift_o  = emit_o;
        done_o   = (phase_q == PH_DONE);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Emitted-bit counter, cleared outside the emit phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (phase_q == PH_EMIT) cnt_q <= cnt_q + 1'b1;
        else                        cnt_q <= '0;
    end

    // R4: done lasts a single cycle.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: done comes right after an emit cycle.
    a_r4_done_after_emit: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(emit_o));

    // R3: the emit run starts only after end of data was seen in the data phase.
    a_r3_emit_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emit_o) |-> $past(phase_q == PH_DATA && eod_i));

    // R5: nothing is absorbed and nothing is preset while emitting or done.
    a_r5_quiet_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_o || done_o) |-> (!absorb_o && !preset_o));

    // R6: an accepted start always opens the data phase.
    a_r6_start_opens_data: assert property (@(posedge clk) disable iff (!rst_n)
        preset_o |=> (phase_q == PH_DATA));

endmodule

// File: rtl/fcs32_serial_gen.sv
`timescale 1ns/1ps
// Module: fcs32_serial_gen
// Top of the bit-serial transmit frame check generator. It divides the covered
// frame bits by the CRC-32 polynomial, with the register preset to ones. It then
// emits the complemented remainder MSB first and pulses done. Assumes covered
// bits arrive only between sof_i and eod_i.
module fcs32_serial_gen
    import fcs32_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic eod_i,
    output logic fcs_bit_o,
    output logic fcs_vld_o,
    output logic done_o
);

    logic preset_w;
    logic absorb_w;
    logic shift_w;
    logic emit_w;
    logic msb_w;

    fcs32_sequencer #(
        .W (CHK_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_i    (sof_i),
        .vld_i    (bit_vld_i),
        .eod_i    (eod_i),
        .preset_o (preset_w),
        .absorb_o (absorb_w),
        .shift_o  (shift_w),
        .emit_o   (emit_w),
        .done_o   (done_o)
    );

    fcs32_divider #(
        .W      (CHK_W),
        .POLY   (CHK_POLY),
        .PRESET (CHK_PRESET)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (preset_w),
        .absorb_i (absorb_w),
        .data_i   (bit_i),
        .shift_i  (shift_w),
        .msb_o    (msb_w)
    );

    // Serial output: the complemented remainder, valid only while emitting.
    always_comb begin
        fcs_vld_o = emit_w;
        fcs_bit_o = emit_w & ~msb_w;
    end

    // R4: valid data and done never overlap at the ports.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(fcs_vld_o && done_o));

    // R1: outputs are quiet in the first cycle after reset is released.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!fcs_vld_o && !done_o));

endmodule

// File: tb/fcs32_serial_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected check bits and the done marker,
// the monitor pops and compares them as the design emits.
module fcs32_serial_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 1'b0, bvld = 1'b0, bdat = 1'b0, eod = 1'b0;
    logic fcs_bit, fcs_vld, done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int arm_from = 1 << 30;

    int    exp_q[$];      // 0/1 = check bit, 2 = done marker
    string tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    fcs32_serial_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_i     (sof),
        .bit_vld_i (bvld),
        .bit_i     (bdat),
        .eod_i     (eod),
        .fcs_bit_o (fcs_bit),
        .fcs_vld_o (fcs_vld),
        .done_o    (done)
    );

    function automatic logic [31:0] model_fcs(input byte unsigned m[$]);
        logic [31:0] r = 32'hFFFF_FFFF;
        logic fb;
        foreach (m[i]) begin
            for (int b = 7; b >= 0; b--) begin
                fb = m[i][b] ^ r[31];
                r = {r[30:0], 1'b0};
                if (fb) r = r ^ 32'h04C1_1DB7;
            end
        end
        return ~r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w, input string tag);
        for (int b = 31; b >= 0; b--) begin
            exp_q.push_back(int'(w[b]));
            tag_q.push_back(tag);
        end
        exp_q.push_back(2);
        tag_q.push_back("R4");
        arm_from = cyc + 1;
    endtask

    // Monitor: compares every output against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fcs_vld || done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected output", {30'd0, fcs_vld, done}, 32'd0);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e == 2)
                        check(done && !fcs_vld, t, "done position", {30'd0, fcs_vld, done}, 32'd1);
                    else
                        check(fcs_vld && !done && (fcs_bit == e[0]), t, "check bit",
                              {31'd0, fcs_bit}, e);
                end
            end else if (cyc >= arm_from && exp_q.size() != 0) begin
                check(1'b0, "R3", "missing output in emit run", 32'd0, 32'd1);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: one frame, with optional gaps, noise during emit and a start strobe mid-data.
    task automatic run_frame(input byte unsigned msg[$], input bit gaps, input bit eod_last,
                             input bit noise, input bit sof_mid,
                             input logic [31:0] exp_word, input string tag);
        bit sent_eod = 1'b0;
        sof = 1'b1; bvld = 1'b0; eod = 1'b0;
        tick();
        sof = 1'b0;
        foreach (msg[i]) begin
            for (int b = 7; b >= 0; b--) begin
                if (gaps && ($urandom % 3 == 0)) begin
                    bvld = 1'b0; bdat = 1'($urandom);
                    tick();
                end
                bvld = 1'b1;
                bdat = msg[i][b];
                sof  = sof_mid && (i == 0) && (b == 5);
                eod  = eod_last && (i == msg.size() - 1) && (b == 0);
                if (eod) begin
                    push_word(exp_word, tag);
                    sent_eod = 1'b1;
                end
                tick();
                sof = 1'b0;
            end
        end
        bvld = 1'b0;
        if (!sent_eod) begin
            eod = 1'b1;
            push_word(exp_word, tag);
            tick();
        end
        eod = 1'b0;
        while (exp_q.size() != 0) begin
            if (noise) begin
                bvld = 1'b1; bdat = 1'($urandom); sof = 1'b1;
            end else begin
                bvld = 1'b0; sof = 1'b0;
            end
            tick();
        end
        sof = 1'b0;
        // Idle bits: absorbed only if a start strobe was wrongly taken (R6).
        repeat (3) begin
            bvld = 1'b1; bdat = 1'($urandom);
            tick();
        end
        bvld = 1'b0;
        tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        byte unsigned kat[$];
        byte unsigned m[$];
        byte unsigned res[$];
        logic [31:0]  w;

        // R1: quiet outputs during reset, including with strobes driven.
        sof = 1'b1; bvld = 1'b1; eod = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!fcs_vld && !done, "R1", "outputs in reset", {30'd0, fcs_vld, done}, 32'd0);
        end
        @(posedge clk); #1;
        sof = 1'b0; bvld = 1'b0; eod = 1'b0;
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!fcs_vld && !done, "R1", "outputs after reset", {30'd0, fcs_vld, done}, 32'd0);
        end
        tick();

        // R2: known answer, and the bench model agrees with it.
        for (int c = 8'h31; c <= 8'h39; c++) kat.push_back(8'(c));
        check(model_fcs(kat) == 32'hFC89_1918, "R2", "bench model known answer",
              model_fcs(kat), 32'hFC89_1918);
        run_frame(kat, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFC89_1918, "R2");

        // R7: empty frame.
        m = {};
        run_frame(m, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, "R7");

        // R9: idle cycles with random bit values inside the frame.
        run_frame(kat, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFC89_1918, "R9");

        // R10: last bit presented together with end of data.
        m = {8'hA5, 8'h0F, 8'hC3};
        run_frame(m, 1'b0, 1'b1, 1'b0, 1'b0, model_fcs(m), "R10");

        // R5 and R6: bits and start strobes during emit and done, then the next frame.
        m = {8'h10, 8'h20, 8'h30, 8'h40};
        run_frame(m, 1'b0, 1'b0, 1'b1, 1'b0, model_fcs(m), "R5");
        run_frame(kat, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFC89_1918, "R6");

        // R6: start strobe in the middle of the data.
        m = {8'hDE, 8'hAD, 8'hBE, 8'hEF};
        run_frame(m, 1'b0, 1'b0, 1'b0, 1'b1, model_fcs(m), "R6");

        // R8: message followed by its own check word.
        res = {8'h01, 8'h23, 8'h45, 8'h67, 8'h89};
        w = model_fcs(res);
        res.push_back(w[31:24]); res.push_back(w[23:16]);
        res.push_back(w[15:8]);  res.push_back(w[7:0]);
        check(model_fcs(res) == 32'h38FB_2284, "R8", "bench model residue",
              model_fcs(res), 32'h38FB_2284);
        run_frame(res, 1'b1, 1'b1, 1'b0, 1'b0, 32'h38FB_2284, "R8");

        // R2: random frames with mixed options.
        for (int f = 0; f < 6; f++) begin
            int n;
            m = {};
            n = 1 + ($urandom % 12);
            for (int k = 0; k < n; k++) m.push_back(8'($urandom));
            run_frame(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      model_fcs(m), "R2");
        end

        repeat (4) tick();
        // R3/R4: every expected bit and done marker was produced.
        check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule